// File: doc/BRIEF.md
# Banked Dual-Load Data Port Arbiter

This block sits in front of a data array that is split into single-ported banks. In each cycle it accepts up to two load requests and one store request. Each address is mapped to a bank and a row. The block then drives every bank's enable, write enable and row address from whichever request owns that bank. Two loads that land in different banks are both served in the same cycle. When they collide, load port 0 takes the bank, and load port 1 sees a not-ready signal and keeps its request up until it is accepted.

A store competes for banks with the loads that have already been granted. If its bank is taken, the store is refused. In the next cycle it takes priority on its bank over both loads, so it never waits more than one cycle. Each bank returns its data one cycle after it is enabled. The block sends that data back on the response channel of the port that was granted, paired with a valid strobe.

Tags, misses, refill and store-to-load forwarding are handled elsewhere.

Top module: `bank_load_arbiter`

## Requirements
- R1: An address maps to bank `addr[5:3]` and row `addr[ADDR_W-1:6]`; a granted request raises `bank_en` of that bank and puts its row on that bank's slice of `bank_addr` (slice b is bits `b*ROW_W +: ROW_W`).
- R2: Two loads to different banks are both ready in the same cycle when no prioritised store holds either bank.
- R3: When both loads are valid and target the same bank outside store priority, load port 0 is ready and load port 1 is not ready; a held port 1 request is accepted once its bank is free.
- R4: An accepted store raises `bank_en` and `bank_we` of its bank with `st_data` on `bank_wdata`, and a later load of that address returns the stored word.
- R5: A valid store whose bank is taken by a granted load is not ready; in the following cycle a still-valid store is ready, and any load aimed at its bank is not ready in that cycle.
- R6: A load granted in cycle n gives `rspX_valid` high in cycle n+1 on its own port, with the data word of its bank; the valid is low when there was no grant.
- R7: While reset is asserted and right after it, both response valids are low and no store priority is pending.
- R8: Each bank serves at most one request per cycle; `bank_en` is exactly the set of banks of the granted requests, and `bank_we` only the store's bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld0_valid | input | 1 | Load port 0 request |
| ld0_addr | input | ADDR_W | Load port 0 byte address |
| ld0_ready | output | 1 | Load port 0 accepted this cycle if valid |
| ld1_valid | input | 1 | Load port 1 request |
| ld1_addr | input | ADDR_W | Load port 1 byte address |
| ld1_ready | output | 1 | Load port 1 accepted this cycle if valid |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data word |
| st_ready | output | 1 | Store accepted this cycle if valid |
| rsp0_valid | output | 1 | Load port 0 read data valid |
| rsp0_data | output | DATA_W | Load port 0 read data |
| rsp1_valid | output | 1 | Load port 1 read data valid |
| rsp1_data | output | DATA_W | Load port 1 read data |
| bank_en | output | NUM_BANKS | Per-bank access enable |
| bank_we | output | NUM_BANKS | Per-bank write enable |
| bank_addr | output | NUM_BANKS*ROW_W | Per-bank row address |
| bank_wdata | output | DATA_W | Write data shared by all banks |
| bank_rdata | input | NUM_BANKS*DATA_W | Per-bank read data, one cycle after enable |

## Verification
Bank arbitration and read-data return overlap in the same cycle. A new pair of loads is decided while the words of the previous grants come back, and a store can write one bank while loads read others. Random stimulus with few distinct banks makes load-load and load-store clashes common. Refused requests are held, as the handshake requires. Each cycle, the bench derives the expected readies, bank enables and returned words from its own bank model and shadow memory, and judges the design against them.

// File: rtl/bla_pkg.sv
package bla_pkg;
  // Bank index from a byte address: skip the word offset, keep bank_w bits.
  function automatic int unsigned bank_of(logic [31:0] a, int unsigned off_w,
                                          int unsigned bank_w);
    return int'((a >> off_w) & ((32'd1 << bank_w) - 32'd1));
  endfunction

  // Row index: everything above the offset and bank fields.
  function automatic int unsigned row_of(logic [31:0] a, int unsigned off_w,
                                         int unsigned bank_w);
    return int'(a >> (off_w + bank_w));
  endfunction
endpackage

// File: rtl/bla_grant.sv
module bla_grant #(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v0,
  input  logic              v1,
  input  logic              vs,
  input  logic [BANK_W-1:0] b0,
  input  logic [BANK_W-1:0] b1,
  input  logic [BANK_W-1:0] bs,
  output logic              r0,
  output logic              r1,
  output logic              rs,
  output logic              g0,
  output logic              g1,
  output logic              gs
);
  logic st_wait_q;
  logic st_prio;
  logic clash01, clash0s, clash1s;

  assign st_prio = st_wait_q & vs;
  assign clash01 = (b0 == b1);
  assign clash0s = (b0 == bs);
  assign clash1s = (b1 == bs);

  always_comb begin
    if (st_prio) begin
      rs = 1'b1;
      r0 = !clash0s;
      r1 = !clash1s && !(v0 && r0 && clash01);
    end else begin
      r0 = 1'b1;
      r1 = !(v0 && clash01);
      rs = !(v0 && clash0s) && !(v1 && r1 && clash1s);
    end
  end

  assign g0 = v0 & r0;
  assign g1 = v1 & r1;
  assign gs = vs & rs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_wait_q <= 1'b0;
    else        st_wait_q <= vs & ~rs;
  end

  // R3: port 0 owns a shared bank outside store priority
  p_ld1_yields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 && v1 && clash01 && !st_wait_q) |-> (r0 && !r1));
  // R5: a refused store is accepted on the next cycle if still valid
  p_store_wait_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vs && !rs) |=> (!vs || rs));
  // R5: loads step aside from the prioritised store's bank
  p_prio_blocks_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_prio && v0 && clash0s) |-> !g0);
endmodule

// File: rtl/bla_bank_mux.sv
module bla_bank_mux #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       g0,
  input  logic                       g1,
  input  logic                       gs,
  input  logic [BANK_W-1:0]          b0,
  input  logic [BANK_W-1:0]          b1,
  input  logic [BANK_W-1:0]          bs,
  input  logic [ROW_W-1:0]           row0,
  input  logic [ROW_W-1:0]           row1,
  input  logic [ROW_W-1:0]           rows,
  output logic [NUM_BANKS-1:0]       bank_en,
  output logic [NUM_BANKS-1:0]       bank_we,
  output logic [NUM_BANKS*ROW_W-1:0] bank_addr
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit0, hit1, hits;
    assign hit0 = g0 && (b0 == BANK_W'(b));
    assign hit1 = g1 && (b1 == BANK_W'(b));
    assign hits = gs && (bs == BANK_W'(b));

    assign bank_en[b] = hit0 | hit1 | hits;
    assign bank_we[b] = hits;
    assign bank_addr[b*ROW_W +: ROW_W] = hits ? rows : (hit0 ? row0 : row1);

    // R8: grant logic never hands one bank to two requesters
    p_bank_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit0, hit1, hits}));
  end
endmodule

// File: rtl/bla_rsp.sv
module bla_rsp #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3,
  parameter int DATA_W    = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        g0,
  input  logic                        g1,
  input  logic [BANK_W-1:0]           b0,
  input  logic [BANK_W-1:0]           b1,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  output logic                        rsp0_valid,
  output logic [DATA_W-1:0]           rsp0_data,
  output logic                        rsp1_valid,
  output logic [DATA_W-1:0]           rsp1_data
);
  logic              gnt0_q, gnt1_q;
  logic [BANK_W-1:0] bank0_q, bank1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt0_q  <= 1'b0;
      gnt1_q  <= 1'b0;
      bank0_q <= '0;
      bank1_q <= '0;
    end else begin
      gnt0_q  <= g0;
      gnt1_q  <= g1;
      if (g0) bank0_q <= b0;
      if (g1) bank1_q <= b1;
    end
  end

  assign rsp0_valid = gnt0_q;
  assign rsp1_valid = gnt1_q;
  assign rsp0_data  = bank_rdata[bank0_q*DATA_W +: DATA_W];
  assign rsp1_data  = bank_rdata[bank1_q*DATA_W +: DATA_W];

  // R6: responses appear exactly one cycle after a grant
  p_rsp0_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    g0 |=> rsp0_valid);
  p_rsp1_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !g1 |=> !rsp1_valid);
endmodule

// File: rtl/bank_load_arbiter.sv
module bank_load_arbiter #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 64,
  parameter int NUM_BANKS  = 8,
  parameter int WORD_BYTES = 8,
  localparam int OFF_W     = $clog2(WORD_BYTES),
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int ROW_W     = ADDR_W - OFF_W - BANK_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld0_valid,
  input  logic [ADDR_W-1:0]           ld0_addr,
  output logic                        ld0_ready,
  input  logic                        ld1_valid,
  input  logic [ADDR_W-1:0]           ld1_addr,
  output logic                        ld1_ready,
  input  logic                        st_valid,
  input  logic [ADDR_W-1:0]           st_addr,
  input  logic [DATA_W-1:0]           st_data,
  output logic                        st_ready,
  output logic                        rsp0_valid,
  output logic [DATA_W-1:0]           rsp0_data,
  output logic                        rsp1_valid,
  output logic [DATA_W-1:0]           rsp1_data,
  output logic [NUM_BANKS-1:0]        bank_en,
  output logic [NUM_BANKS-1:0]        bank_we,
  output logic [NUM_BANKS*ROW_W-1:0]  bank_addr,
  output logic [DATA_W-1:0]           bank_wdata,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata
);
  import bla_pkg::*;

  logic [BANK_W-1:0] b0, b1, bs;
  logic [ROW_W-1:0]  row0, row1, rows;
  logic              g0, g1, gs;

  assign b0   = BANK_W'(bank_of(32'(ld0_addr), OFF_W, BANK_W));
  assign b1   = BANK_W'(bank_of(32'(ld1_addr), OFF_W, BANK_W));
  assign bs   = BANK_W'(bank_of(32'(st_addr),  OFF_W, BANK_W));
  assign row0 = ROW_W'(row_of(32'(ld0_addr), OFF_W, BANK_W));
  assign row1 = ROW_W'(row_of(32'(ld1_addr), OFF_W, BANK_W));
  assign rows = ROW_W'(row_of(32'(st_addr),  OFF_W, BANK_W));

  bla_grant #(.BANK_W(BANK_W)) u_grant (
    .clk(clk), .rst_n(rst_n),
    .v0(ld0_valid), .v1(ld1_valid), .vs(st_valid),
    .b0(b0), .b1(b1), .bs(bs),
    .r0(ld0_ready), .r1(ld1_ready), .rs(st_ready),
    .g0(g0), .g1(g1), .gs(gs)
  );

  bla_bank_mux #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .g0(g0), .g1(g1), .gs(gs),
    .b0(b0), .b1(b1), .bs(bs),
    .row0(row0), .row1(row1), .rows(rows),
    .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr)
  );

  bla_rsp #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .g0(g0), .g1(g1), .b0(b0), .b1(b1),
    .bank_rdata(bank_rdata),
    .rsp0_valid(rsp0_valid), .rsp0_data(rsp0_data),
    .rsp1_valid(rsp1_valid), .rsp1_data(rsp1_data)
  );

  assign bank_wdata = st_data;

  // R4: a store that is accepted writes its own bank
  p_store_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |-> bank_we[bs]);
endmodule

// File: tb/bank_load_arbiter_bench.sv
`timescale 1ns/1ps
module bank_load_arbiter_bench;
  localparam int AW = 12, DW = 64, NB = 8, RW = 6, ROWS = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          ld0_valid = 0, ld1_valid = 0, st_valid = 0;
  logic [AW-1:0] ld0_addr = '0, ld1_addr = '0, st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          ld0_ready, ld1_ready, st_ready, rsp0_valid, rsp1_valid;
  logic [DW-1:0] rsp0_data, rsp1_data, bank_wdata;
  logic [NB-1:0] bank_en, bank_we;
  logic [NB*RW-1:0] bank_addr;
  logic [NB*DW-1:0] bank_rdata;

  bank_load_arbiter u_bank_load_arbiter (.*);

  // Bank array model: synchronous single-port banks
  logic [DW-1:0] bmem [NB][ROWS];
  logic [DW-1:0] rdq  [NB];
  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (bank_en[b] && bank_we[b]) bmem[b][bank_addr[b*RW +: RW]] <= bank_wdata;
      else if (bank_en[b])          rdq[b] <= bmem[b][bank_addr[b*RW +: RW]];
    end
  end
  for (genvar b = 0; b < NB; b++) begin : g_rd
    assign bank_rdata[b*DW +: DW] = rdq[b];
  end

  // Shadow memory indexed by word address
  logic [DW-1:0] smem [NB*ROWS];
  int checks = 0, failures = 0;
  bit done = 0;
  bit prio = 0;
  bit pg0 = 0, pg1 = 0;
  logic [DW-1:0] pd0 = '0, pd1 = '0;

  function automatic int bk(logic [AW-1:0] a); return int'(a[5:3]); endfunction
  function automatic int wd(logic [AW-1:0] a); return int'(a >> 3); endfunction

  // Reference readiness: {rs, r1, r0}
  function automatic logic [2:0] ref_ready(bit p, bit v0, logic [AW-1:0] a0,
      bit v1, logic [AW-1:0] a1, bit vs, logic [AW-1:0] as);
    bit r0, r1, rs;
    if (p && vs) begin
      rs = 1;
      r0 = bk(a0) != bk(as);
      r1 = (bk(a1) != bk(as)) && !(v0 && r0 && bk(a0) == bk(a1));
    end else begin
      r0 = 1;
      r1 = !(v0 && bk(a0) == bk(a1));
      rs = !(v0 && bk(a0) == bk(as)) && !(v1 && r1 && bk(a1) == bk(as));
    end
    return {rs, r1, r0};
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: check last responses, apply inputs, check readiness and banks
  task automatic cycle(bit v0, logic [AW-1:0] a0, bit v1, logic [AW-1:0] a1,
                       bit vs, logic [AW-1:0] as, logic [DW-1:0] d,
                       output logic [2:0] rdy);
    logic [2:0] e;
    logic [NB-1:0] een, ewe;
    @(negedge clk);
    chk(rsp0_valid == pg0, "R6 rsp0_valid", DW'(rsp0_valid), DW'(pg0));
    if (pg0) chk(rsp0_data == pd0, "R1/R4 rsp0_data", rsp0_data, pd0);
    chk(rsp1_valid == pg1, "R6 rsp1_valid", DW'(rsp1_valid), DW'(pg1));
    if (pg1) chk(rsp1_data == pd1, "R1/R4 rsp1_data", rsp1_data, pd1);
    ld0_valid = v0; ld0_addr = a0; ld1_valid = v1; ld1_addr = a1;
    st_valid = vs; st_addr = as; st_data = d;
    #1;
    e = ref_ready(prio, v0, a0, v1, a1, vs, as);
    if (v0) chk(ld0_ready == e[0], "R2/R5 ld0_ready", DW'(ld0_ready), DW'(e[0]));
    if (v1) chk(ld1_ready == e[1], "R3 ld1_ready", DW'(ld1_ready), DW'(e[1]));
    if (vs) chk(st_ready == e[2], "R5 st_ready", DW'(st_ready), DW'(e[2]));
    een = '0; ewe = '0;
    if (v0 && e[0]) een[bk(a0)] = 1;
    if (v1 && e[1]) een[bk(a1)] = 1;
    if (vs && e[2]) begin een[bk(as)] = 1; ewe[bk(as)] = 1; end
    chk(bank_en == een, "R8 bank_en", DW'(bank_en), DW'(een));
    chk(bank_we == ewe, "R8 bank_we", DW'(bank_we), DW'(ewe));
    if (v0 && e[0])
      chk(bank_addr[bk(a0)*RW +: RW] == a0[AW-1:6], "R1 bank_addr",
          DW'(bank_addr[bk(a0)*RW +: RW]), DW'(a0[AW-1:6]));
    if (vs && e[2]) chk(bank_wdata == d, "R4 bank_wdata", bank_wdata, d);
    pg0 = v0 && e[0]; pd0 = smem[wd(a0)];
    pg1 = v1 && e[1]; pd1 = smem[wd(a1)];
    if (vs && e[2]) smem[wd(as)] = d;
    prio = vs && !e[2];
    rdy = e;
  endtask

  function automatic logic [AW-1:0] mk(int row, int bank);
    return AW'((row << 6) | (bank << 3));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] r;
    bit h0, h1, hs;
    logic [AW-1:0] a0, a1, as;
    logic [DW-1:0] d;
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < NB*ROWS; i++) begin
      smem[i] = {32'hA5A5_0000 | 32'(i), 32'(i) * 32'h9E37_79B9};
      bmem[i % NB][i / NB] = smem[i];
    end
    for (int b = 0; b < NB; b++) rdq[b] = '0;
    repeat (3) @(negedge clk);
    chk(!rsp0_valid && !rsp1_valid, "R7 reset rsp", DW'({rsp0_valid, rsp1_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp0_valid && !rsp1_valid, "R7 after reset rsp",
        DW'({rsp0_valid, rsp1_valid}), 0);
    // R7: no stale store priority: load 0 wins its bank against a first store
    cycle(1, mk(1, 4), 0, '0, 1, mk(2, 4), 64'h11, r);
    chk(r[0] && !r[2], "R7 no prio after reset", DW'(r), 3'b001);
    cycle(0, '0, 0, '0, 1, mk(2, 4), 64'h11, r);       // R5 store now taken
    // R2: different banks
    cycle(1, mk(5, 2), 1, mk(9, 5), 0, '0, '0, r);
    // R3: same bank, ld1 held then accepted
    cycle(1, mk(3, 3), 1, mk(7, 3), 0, '0, '0, r);
    chk(r[1:0] == 2'b01, "R3 clash", DW'(r[1:0]), 2'b01);
    cycle(0, '0, 1, mk(7, 3), 0, '0, '0, r);
    // R5: store refused, then prioritised over loads on its bank
    cycle(1, mk(4, 6), 0, '0, 1, mk(8, 6), 64'hDEAD_BEEF, r);
    cycle(1, mk(5, 6), 1, mk(6, 1), 1, mk(8, 6), 64'hDEAD_BEEF, r);
    chk(r == 3'b110, "R5 prio", DW'(r), 3'b110);
    // R4: read back the stored word
    cycle(1, mk(8, 6), 1, mk(2, 4), 0, '0, '0, r);
    // Random with hold-on-refusal
    h0 = 0; h1 = 0; hs = 0; a0 = '0; a1 = '0; as = '0; d = '0;
    for (int n = 0; n < 2000; n++) begin
      bit v0, v1, vs;
      v0 = h0 ? 1'b1 : ($urandom % 4 != 0);
      v1 = h1 ? 1'b1 : ($urandom % 4 != 0);
      vs = hs ? 1'b1 : ($urandom % 3 == 0);
      if (!h0) a0 = mk(int'($urandom % ROWS), int'($urandom % 3));
      if (!h1) a1 = mk(int'($urandom % ROWS), int'($urandom % 3));
      if (!hs) begin
        as = mk(int'($urandom % ROWS), int'($urandom % 4));
        d  = {$urandom, $urandom};
      end
      cycle(v0, a0, v1, a1, vs, as, d, r);
      h0 = v0 && !r[0]; h1 = v1 && !r[1]; hs = vs && !r[2];
    end
    cycle(0, '0, 0, '0, 0, '0, '0, r);
    cycle(0, '0, 0, '0, 0, '0, '0, r);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule